// File: doc/BRIEF.md
# Programmable Expansion Bus Clock Generator

This block derives two timing signals from one primary clock. The first is the expansion bus clock. The second is a processor clock enable. The bus clock comes from one of two sources. The first is the primary clock itself. The second is a slower bus oscillator that may or may not be fitted on a shared input pin. Just after reset the block counts the oscillator's edges over a fixed window. Enough edges select asynchronous mode, where the oscillator paces the bus clock. Too few select synchronous mode, where the primary clock paces it. The result is held until the next reset.

Two divisor codes are kept in a clock control register. A standard code is loaded from strap pins at reset, and a fast code resets to divide-by-6. The fast code applies to accesses that fall in the video memory window. In synchronous mode it also applies while the shared pin is high. That pin has a pull-up, so an unconnected pin selects the fast code. The chosen divisor is latched only at a rising bus clock edge, so no phase is ever shortened.

Software reaches the register through a two-port scheme: an index port and a data port. The same register also holds the processor clock divisor and two read-only detection flags.

Top module: `atbus_clkgen`

## Requirements
- R1: After reset, the pin's synchronised rising edges are counted over 1024 primary cycles. Eight or more edges select asynchronous mode and fewer select synchronous mode. The mode flag is bit 7 of the control register (1 = asynchronous) and the detection-complete flag is bit 6. The bus clock stays low until detection completes.
- R2: In synchronous mode the bus clock runs at the primary clock divided by 2, 4, 6 or 8 for divisor codes 0, 1, 2 and 3, with equal high and low phases of (code+1) primary cycles.
- R3: In asynchronous mode each phase of the bus clock lasts (code+1) rising edges of the oscillator, giving oscillator/2, /4, /6 or /8.
- R4: In synchronous mode a high pin level selects the fast code and a low level selects the standard code. In asynchronous mode the pin level does not select a code.
- R5: When acc_valid is high and acc_addr lies within 0xA0000 to 0xBFFFF inclusive, the fast code is used in either mode. Addresses outside that range, or acc_valid low, do not select it.
- R6: A new divisor takes effect only at a rising edge of the bus clock, using the selection in force in that cycle. A phase already under way keeps its length.
- R7: Port 0 (cfg_port=0) holds the index. Port 1 reaches the register at index 0x07, laid out as standard code in bits 1:0, fast code in bits 3:2, processor code in bits 5:4, and the flags in bits 7:6. Any other index reads 0, and writes to it change nothing.
- R8: Reset sets the index to 0, the fast code to 2, the processor code to 0, and the standard code to strap_std.
- R9: cpu_tick pulses once every (code+1) primary cycles for processor codes 0 to 3.
- R10: The detected mode holds until the next reset, even if the oscillator stops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Primary clock |
| rst | input | 1 | Synchronous reset, active high |
| osc_pin | input | 1 | Bus oscillator or static select level (pulled up externally) |
| strap_std | input | 2 | Reset value of the standard divisor code |
| acc_valid | input | 1 | Current access address is valid |
| acc_addr | input | 24 | Current access address |
| cfg_we | input | 1 | Register port write strobe |
| cfg_port | input | 1 | 0 = index port, 1 = data port |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Register read data (combinational) |
| bus_clk | output | 1 | Expansion bus clock |
| cpu_tick | output | 1 | Processor clock enable pulse |

## Verification
Divisor selection and the rising bus clock boundary can land in the same cycle. A one-cycle video-window access is the case where this matters most. The bench times that access from an observed falling edge. In one run it lands exactly on the cycle of the next rise, and the following period must then use the fast divisor. In another run it lands one cycle earlier, and the period must keep the standard divisor. A register write made while a high phase is under way is checked the same way: the current period must keep its old length, and the new divisor must appear only from the next rise.

// File: rtl/atclk_pkg.sv
package atclk_pkg;

   localparam int unsigned CODE_W = 2;
   localparam int unsigned HALF_W = CODE_W + 1;

   typedef logic [CODE_W-1:0] div_code_t;
   typedef logic [HALF_W-1:0] half_t;

   localparam logic [7:0] CTL_INDEX       = 8'h07;
   localparam div_code_t  FAST_RESET_CODE = 2'd2;
   localparam div_code_t  CPU_RESET_CODE  = 2'd0;

   typedef struct packed {
      div_code_t cpu;
      div_code_t fast;
      div_code_t std;
   } clk_ctl_t;

   // phase length in source ticks for a bus divisor code
   function automatic half_t half_ticks(input div_code_t code);
      return {1'b0, code} + half_t'(1);
   endfunction

endpackage

// File: rtl/atclk_detect.sv
module atclk_detect
   import atclk_pkg::*;
#(
   parameter int unsigned WINDOW      = 1024,
   parameter int unsigned MIN_EDGES   = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic osc_pin,
   output logic pin_sync,
   output logic osc_edge,
   output logic done,
   output logic present
);

   localparam int unsigned WIN_W  = $clog2(WINDOW);
   localparam int unsigned EDGE_W = $clog2(MIN_EDGES + 1);
   localparam logic [WIN_W-1:0]  WIN_LAST = WIN_W'(WINDOW - 1);
   localparam logic [EDGE_W-1:0] EDGE_SAT = EDGE_W'(MIN_EDGES);

   generate
      if (WINDOW < 2)      $error("detect window too short");
      if (MIN_EDGES < 1)   $error("edge threshold must be positive");
      if (SYNC_STAGES < 2) $error("at least two synchroniser stages");
   endgenerate

   logic [SYNC_STAGES:0] sync_q;
   logic [WIN_W-1:0]     win_q;
   logic [EDGE_W-1:0]    edge_q, edge_nxt;
   logic                 done_q, present_q;

   always_ff @(posedge clk) begin
      if (rst) sync_q <= '0;
      else     sync_q <= {sync_q[SYNC_STAGES-1:0], osc_pin};
   end

   assign pin_sync = sync_q[SYNC_STAGES-1];
   assign osc_edge = sync_q[SYNC_STAGES-1] & ~sync_q[SYNC_STAGES];

   always_comb begin
      edge_nxt = edge_q;
      if (osc_edge && edge_q != EDGE_SAT) edge_nxt = edge_q + EDGE_W'(1);
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         win_q     <= '0;
         edge_q    <= '0;
         done_q    <= 1'b0;
         present_q <= 1'b0;
      end else if (!done_q) begin
         win_q  <= win_q + WIN_W'(1);
         edge_q <= edge_nxt;
         if (win_q == WIN_LAST) begin
            done_q    <= 1'b1;
            present_q <= (edge_nxt >= EDGE_SAT);
         end
      end
   end

   assign done    = done_q;
   assign present = present_q;

   // R10
   done_hold_chk: assert property (@(posedge clk) disable iff (rst)
      done_q |=> done_q && $stable(present_q));

   // R1
   present_needs_done_chk: assert property (@(posedge clk) disable iff (rst)
      present_q |-> done_q);

endmodule

// File: rtl/atclk_cfg.sv
module atclk_cfg
   import atclk_pkg::*;
(
   input  logic       clk,
   input  logic       rst,
   input  div_code_t  strap_std,
   input  logic       we,
   input  logic       port,
   input  logic [7:0] wdata,
   input  logic       det_done,
   input  logic       det_present,
   output logic [7:0] rdata,
   output clk_ctl_t   ctl
);

   localparam int unsigned CTL_W = $bits(clk_ctl_t);

   generate
      if (CTL_W + 2 > 8) $error("control fields exceed register width");
   endgenerate

   logic [7:0] index_q;
   clk_ctl_t   ctl_q;
   logic       wdata_unused;

   assign wdata_unused = ^wdata[7:CTL_W];

   always_ff @(posedge clk) begin
      if (rst) begin
         index_q <= 8'h00;
         ctl_q   <= '{cpu: CPU_RESET_CODE, fast: FAST_RESET_CODE, std: strap_std};
      end else if (we) begin
         if (!port)                   index_q <= wdata;
         else if (index_q == CTL_INDEX) ctl_q <= clk_ctl_t'(wdata[CTL_W-1:0]);
      end
   end

   always_comb begin
      if (!port)                     rdata = index_q;
      else if (index_q == CTL_INDEX) rdata = {det_present, det_done, ctl_q};
      else                           rdata = 8'h00;
   end

   assign ctl = ctl_q;

   // R7
   foreign_index_chk: assert property (@(posedge clk) disable iff (rst)
      we && port && index_q != CTL_INDEX |=> $stable(ctl_q));

   // R8
   reset_value_chk: assert property (@(posedge clk)
      $past(rst) && !rst |-> ctl_q.fast == FAST_RESET_CODE &&
                             ctl_q.cpu == CPU_RESET_CODE &&
                             ctl_q.std == $past(strap_std) && index_q == 8'h00);

endmodule

// File: rtl/atclk_cpudiv.sv
module atclk_cpudiv
   import atclk_pkg::*;
(
   input  logic      clk,
   input  logic      rst,
   input  div_code_t code,
   output logic      tick
);

   div_code_t cnt_q;
   logic      tick_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q  <= '0;
         tick_q <= 1'b0;
      end else if (cnt_q >= code) begin
         cnt_q  <= '0;
         tick_q <= 1'b1;
      end else begin
         cnt_q  <= cnt_q + CODE_W'(1);
         tick_q <= 1'b0;
      end
   end

   assign tick = tick_q;

   // R9
   full_rate_chk: assert property (@(posedge clk) disable iff (rst)
      tick_q && code == '0 |=> tick_q);

   // R9
   no_double_tick_chk: assert property (@(posedge clk) disable iff (rst)
      tick_q && code != '0 |=> !tick_q);

endmodule

// File: rtl/atclk_busdiv.sv
module atclk_busdiv
   import atclk_pkg::*;
(
   input  logic      clk,
   input  logic      rst,
   input  logic      run,
   input  logic      src_tick,
   input  div_code_t sel_code,
   output logic      bus_clk
);

   half_t half_q, cnt_q, sel_half;
   logic  clk_q;

   assign sel_half = half_ticks(sel_code);

   always_ff @(posedge clk) begin
      if (rst) begin
         clk_q  <= 1'b0;
         cnt_q  <= '0;
         half_q <= half_t'(1);
      end else if (!run) begin
         clk_q  <= 1'b0;
         cnt_q  <= '0;
         half_q <= sel_half;
      end else if (src_tick) begin
         if (cnt_q == half_q - half_t'(1)) begin
            cnt_q <= '0;
            clk_q <= ~clk_q;
            if (!clk_q) half_q <= sel_half;
         end else begin
            cnt_q <= cnt_q + half_t'(1);
         end
      end
   end

   assign bus_clk = clk_q;

   // R6
   half_only_at_rise_chk: assert property (@(posedge clk) disable iff (rst)
      $past(run) && $changed(half_q) |-> $rose(clk_q));

   // R2
   cnt_in_phase_chk: assert property (@(posedge clk) disable iff (rst)
      cnt_q < half_q);

endmodule

// File: rtl/atbus_clkgen.sv
module atbus_clkgen
   import atclk_pkg::*;
#(
   parameter int unsigned           ADDR_W        = 24,
   parameter logic [ADDR_W-1:0]     WIN_LO        = 'h0A0000,
   parameter logic [ADDR_W-1:0]     WIN_HI        = 'h0BFFFF,
   parameter bit                    WINDOW_EN     = 1'b1,
   parameter int unsigned           DET_WINDOW    = 1024,
   parameter int unsigned           DET_MIN_EDGES = 8,
   parameter int unsigned           SYNC_STAGES   = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              osc_pin,
   input  logic [1:0]        strap_std,
   input  logic              acc_valid,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic              cfg_we,
   input  logic              cfg_port,
   input  logic [7:0]        cfg_wdata,
   output logic [7:0]        cfg_rdata,
   output logic              bus_clk,
   output logic              cpu_tick
);

   generate
      if (WIN_LO > WIN_HI) $error("video window bounds reversed");
      if (CODE_W != 2)     $error("port strap width assumes two-bit codes");
   endgenerate

   logic      pin_sync, osc_edge, det_done, det_present;
   logic      in_win, sel_fast, src_tick;
   clk_ctl_t  ctl;
   div_code_t sel_code;

   atclk_detect #(
      .WINDOW(DET_WINDOW), .MIN_EDGES(DET_MIN_EDGES), .SYNC_STAGES(SYNC_STAGES)
   ) u_detect (
      .clk(clk), .rst(rst), .osc_pin(osc_pin), .pin_sync(pin_sync),
      .osc_edge(osc_edge), .done(det_done), .present(det_present)
   );

   atclk_cfg u_cfg (
      .clk(clk), .rst(rst), .strap_std(div_code_t'(strap_std)), .we(cfg_we),
      .port(cfg_port), .wdata(cfg_wdata), .det_done(det_done),
      .det_present(det_present), .rdata(cfg_rdata), .ctl(ctl)
   );

   generate
      if (WINDOW_EN) begin : g_win
         assign in_win = acc_valid && (acc_addr >= WIN_LO) && (acc_addr <= WIN_HI);
      end else begin : g_nowin
         logic acc_unused;
         assign acc_unused = acc_valid ^ (^acc_addr);
         assign in_win = 1'b0;
      end
   endgenerate

   assign sel_fast = in_win || (!det_present && pin_sync);
   assign sel_code = sel_fast ? ctl.fast : ctl.std;
   assign src_tick = det_present ? osc_edge : 1'b1;

   atclk_busdiv u_busdiv (
      .clk(clk), .rst(rst), .run(det_done), .src_tick(src_tick),
      .sel_code(sel_code), .bus_clk(bus_clk)
   );

   atclk_cpudiv u_cpudiv (
      .clk(clk), .rst(rst), .code(ctl.cpu), .tick(cpu_tick)
   );

   // R1
   idle_before_detect_chk: assert property (@(posedge clk) disable iff (rst)
      !det_done |-> !bus_clk);

   // R3
   async_paced_by_osc_chk: assert property (@(posedge clk) disable iff (rst)
      det_present && $changed(bus_clk) |-> $past(osc_edge));

endmodule

// File: tb/atbus_clkgen_bench.sv
module atbus_clkgen_bench;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [1:0]  strap_std = 2'd1;
   logic        acc_valid = 1'b0;
   logic [23:0] acc_addr = 24'h0;
   logic        cfg_we = 1'b0;
   logic        cfg_port = 1'b0;
   logic [7:0]  cfg_wdata = 8'h0;
   logic [7:0]  cfg_rdata;
   logic        bus_clk, cpu_tick;
   logic        pin_lvl = 1'b1;
   logic        osc_run = 1'b0;
   logic        osc_gen = 1'b0;
   logic        osc_pin;
   int          osc_cnt = 0;
   int          tests = 0, fails = 0;
   int          cycles = 0;
   localparam int OSC_HALF = 3;

   assign osc_pin = osc_run ? osc_gen : pin_lvl;

   always #4 clk = ~clk;

   atbus_clkgen u_atbus_clkgen (
      .clk(clk), .rst(rst), .osc_pin(osc_pin), .strap_std(strap_std),
      .acc_valid(acc_valid), .acc_addr(acc_addr), .cfg_we(cfg_we),
      .cfg_port(cfg_port), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
      .bus_clk(bus_clk), .cpu_tick(cpu_tick)
   );

   always @(negedge clk) begin
      if (osc_run) begin
         if (osc_cnt == OSC_HALF - 1) begin
            osc_cnt = 0;
            osc_gen = ~osc_gen;
         end else osc_cnt = osc_cnt + 1;
      end
   end

   always @(posedge clk) begin
      cycles = cycles + 1;
      if (cycles > 150000) begin
         fails = fails + 1;
         tests = tests + 1;
         $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      tests = tests + 1;
      if (act != exp) begin
         fails = fails + 1;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic do_reset(input logic [1:0] strap);
      strap_std = strap;
      rst = 1'b1;
      repeat (4) @(negedge clk);
      rst = 1'b0;
   endtask

   task automatic wr(input logic port, input logic [7:0] d);
      cfg_port = port; cfg_wdata = d; cfg_we = 1'b1;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic rd(input logic port, output logic [7:0] v);
      cfg_port = port;
      #1;
      v = cfg_rdata;
   endtask

   task automatic set_ctl(input int sc, input int fc, input int cc);
      wr(1'b0, 8'h07);
      wr(1'b1, 8'((cc << 4) | (fc << 2) | sc));
      repeat (3) @(negedge clk);
   endtask

   task automatic wait_rise();
      logic p;
      p = bus_clk;
      @(negedge clk);
      while (!(p == 1'b0 && bus_clk == 1'b1)) begin
         p = bus_clk;
         @(negedge clk);
      end
   endtask

   task automatic wait_fall();
      logic p;
      p = bus_clk;
      @(negedge clk);
      while (!(p == 1'b1 && bus_clk == 1'b0)) begin
         p = bus_clk;
         @(negedge clk);
      end
   endtask

   // count the rest of a high phase and the following low phase
   task automatic count_phases(input int h0, output int hi, output int lo);
      hi = h0;
      while (bus_clk) begin hi++; @(negedge clk); end
      lo = 0;
      while (!bus_clk) begin lo++; @(negedge clk); end
   endtask

   task automatic meas_chk(input string req, input int exp_half);
      int hi, lo;
      wait_rise();
      count_phases(0, hi, lo);
      chk({req, " high"}, hi, exp_half);
      chk({req, " low"}, lo, exp_half);
   endtask

   task automatic tick_gap_chk(input string req, input int exp_gap);
      int gap;
      while (!cpu_tick) @(negedge clk);
      @(negedge clk);
      gap = 1;
      while (!cpu_tick) begin gap++; @(negedge clk); end
      chk(req, gap, exp_gap);
   endtask

   task automatic pulses(input int n);
      for (int i = 0; i < n; i++) begin
         pin_lvl = 1'b1; repeat (3) @(negedge clk);
         pin_lvl = 1'b0; repeat (3) @(negedge clk);
      end
   endtask

   initial begin
      logic [7:0] v;
      int hi, lo;

      // synchronous mode, pin left high by its pull-up, strap /4
      pin_lvl = 1'b1;
      @(negedge clk);
      do_reset(2'd1);
      rd(1'b0, v);
      chk("R8 index reset", v, 0);
      repeat (500) @(negedge clk);
      chk("R1 bus clock idle during detection", bus_clk, 0);
      wr(1'b0, 8'h07);
      rd(1'b1, v);
      chk("R1 detection not done", v[6], 0);
      repeat (700) @(negedge clk);
      rd(1'b1, v);
      chk("R8 R1 control after reset", v, 8'h49);
      meas_chk("R4 pull-up fast /6", 3);

      pin_lvl = 1'b0;
      repeat (4) @(negedge clk);
      meas_chk("R4 pin low standard /4", 2);

      for (int c = 0; c < 4; c++) begin
         set_ctl(c, 2, 0);
         meas_chk("R2 sync divisor", c + 1);
      end

      // address window, pin low
      set_ctl(3, 0, 0);
      acc_valid = 1'b1; acc_addr = 24'h0A0000; repeat (2) @(negedge clk);
      meas_chk("R5 window low bound", 1);
      acc_addr = 24'h0BFFFF; repeat (2) @(negedge clk);
      meas_chk("R5 window high bound", 1);
      acc_addr = 24'h09FFFF; repeat (2) @(negedge clk);
      meas_chk("R5 below window", 4);
      acc_addr = 24'h0C0000; repeat (2) @(negedge clk);
      meas_chk("R5 above window", 4);
      acc_valid = 1'b0; acc_addr = 24'h0A0000; repeat (2) @(negedge clk);
      meas_chk("R5 invalid access", 4);

      // divisor written during a high phase
      wait_rise();
      wr(1'b1, 8'h00);
      count_phases(1, hi, lo);
      chk("R6 running high phase kept", hi, 4);
      chk("R6 running low phase kept", lo, 4);
      meas_chk("R6 new divisor from next rise", 1);

      // window access on the exact rising-boundary cycle
      set_ctl(3, 0, 0);
      wait_fall();
      repeat (3) @(negedge clk);
      acc_valid = 1'b1; acc_addr = 24'h0B0000;
      @(negedge clk);
      acc_valid = 1'b0;
      count_phases(0, hi, lo);
      chk("R6 R5 window at rise high", hi, 1);
      chk("R6 R5 window at rise low", lo, 1);
      meas_chk("R6 window released", 4);
      // one cycle early: no rise in that cycle, no effect
      wait_fall();
      repeat (2) @(negedge clk);
      acc_valid = 1'b1;
      @(negedge clk);
      acc_valid = 1'b0;
      meas_chk("R6 window before rise ignored", 4);

      // processor clock enable
      for (int c = 0; c < 4; c++) begin
         set_ctl(1, 2, c);
         tick_gap_chk("R9 cpu tick period", c + 1);
      end

      // foreign index
      set_ctl(1, 2, 1);
      wr(1'b0, 8'h03);
      wr(1'b1, 8'hFF);
      rd(1'b1, v);
      chk("R7 foreign index reads zero", v, 0);
      rd(1'b0, v);
      chk("R7 index readback", v, 3);
      wr(1'b0, 8'h07);
      rd(1'b1, v);
      chk("R7 control untouched", v, 8'h59);

      // reset after writes, other strap
      do_reset(2'd2);
      repeat (1100) @(negedge clk);
      wr(1'b0, 8'h07);
      rd(1'b1, v);
      chk("R8 control after second reset", v, 8'h4A);
      tick_gap_chk("R8 cpu code reset", 1);

      // edge threshold boundary
      pin_lvl = 1'b0;
      do_reset(2'd1);
      pulses(7);
      repeat (1100) @(negedge clk);
      wr(1'b0, 8'h07);
      rd(1'b1, v);
      chk("R1 seven edges sync", v[7], 0);
      do_reset(2'd1);
      pulses(8);
      repeat (1100) @(negedge clk);
      wr(1'b0, 8'h07);
      rd(1'b1, v);
      chk("R1 eight edges async", v[7], 1);

      // asynchronous mode with a running oscillator
      osc_run = 1'b1;
      do_reset(2'd1);
      repeat (1100) @(negedge clk);
      wr(1'b0, 8'h07);
      rd(1'b1, v);
      chk("R1 oscillator detected", v[7:6], 3);
      for (int c = 0; c < 4; c++) begin
         set_ctl(c, 0, 0);
         meas_chk("R3 async divisor", (c + 1) * 2 * OSC_HALF);
      end
      set_ctl(1, 0, 0);
      meas_chk("R4 async pin ignored first", 2 * 2 * OSC_HALF);
      meas_chk("R4 async pin ignored second", 2 * 2 * OSC_HALF);
      acc_valid = 1'b1; acc_addr = 24'h0A8000; repeat (2) @(negedge clk);
      meas_chk("R5 async window fast", 2 * OSC_HALF);
      acc_valid = 1'b0;

      // oscillator stops: mode held
      osc_run = 1'b0;
      pin_lvl = 1'b0;
      repeat (60) @(negedge clk);
      rd(1'b1, v);
      chk("R10 mode held after stop", v[7], 1);

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule